// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block links a three-state logic-side port (A) to an open-collector, wired-OR backplane port (B) across a parameterised number of bit lanes (nine by default). Each direction has its own storage element. A two-bit mode code picks, for each direction, pass-through, a latch that is transparent while its control pin is low, or a register that loads on the rising edge of that pin. One code runs the two directions in different modes. Every path inverts: the data on the output side is always the complement of the data received.

Each port is modelled as separate drive, enable and receive signals. The A side drives `a_do` whenever `a_oe` is high. The B side can only pull a line low. `b_pull[i]` high means lane i is pulled low, and a released lane reads high through the bus pull-up. A power-good input holds the B drivers released while supplies are ramping. The storage elements have no reset, so their contents are undefined until data is loaded.

Top module: `bidir_bus_xcvr`

## Requirements
- R1: The mode code `mode_sel` selects the storage kind for each direction: 2'b00 is latch in both directions, 2'b01 is pass-through in both, 2'b10 is register in both, and 2'b11 is register for A-to-B and latch for B-to-A.
- R2: In every mode the output is the bitwise inverse of the data seen by the path. In pass-through, B line level = ~`a_di` and `a_do` = ~(received B data).
- R3: In register mode a direction loads its input on the rising edge of its own control pin (`clk_ab` for A-to-B, `clk_ba` for B-to-A). An edge on the other direction's pin has no effect on it.
- R4: In latch mode a direction follows its input while its control pin is low and holds the last value while the pin is high.
- R5: `a_oe` is high exactly when `a_en` is high. `a_do` carries the B-to-A output.
- R6: B drive is active only when `b_en0` = 1 and `b_en1` = 0. For any other pair `b_pull` is all zeros, so every line is released.
- R7: B is open-collector: `b_pull[i]` = 1 only for lanes whose output level is low. A high output is produced by releasing the lane.
- R8: Storage keeps loading or holding while its output port is disabled. Data loaded while disabled appears when the port is re-enabled.
- R9: A B lane flagged by `b_float[i]` = 1 is received as logic low, whatever `b_di[i]` holds.
- R10: While `pwr_good` is low, `b_pull` is all zeros regardless of the enables. The A port is not affected.
- R11: A change of `mode_sel` switches the outputs to the newly selected element's contents in the same cycle, with no edge on `clk_ab` or `clk_ba`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_sel | input | 2 | Mode code per R1 |
| clk_ab | input | 1 | A-to-B register clock / latch control (transparent low) |
| clk_ba | input | 1 | B-to-A register clock / latch control (transparent low) |
| pwr_good | input | 1 | Supplies valid; low forces B drivers released |
| a_en | input | 1 | A port output enable, active high |
| b_en0 | input | 1 | B enable, must be high to drive |
| b_en1 | input | 1 | B enable, must be low to drive |
| a_di | input | W | A port received data |
| a_do | output | W | A port drive value |
| a_oe | output | 1 | A port drive enable |
| b_di | input | W | B port received line levels |
| b_float | input | W | Per lane: nothing drives the B line |
| b_pull | output | W | Per lane: pull the B line low |

## Verification
The register and pass-through properties are sampled on the rising edges of `clk_ab` and `clk_ba`. They assume that `a_di`, `b_di`, `b_float`, `mode_sel` and the enables are stable around those edges, and that data never changes in the same instant as a control pin. They also assume that `pwr_good` has been high since an earlier edge of the same pin. The stimulus changes data and control only on the bench clock's falling edge, in steps that are separate from the steps that move `clk_ab` or `clk_ba`. It also raises `pwr_good` before the first control-pin edge.

// File: rtl/bidir_xcvr_pkg.sv
package bidir_xcvr_pkg;

  typedef enum logic [1:0] {
    SEL_LATCH = 2'b00,
    SEL_THRU  = 2'b01,
    SEL_REG   = 2'b10,
    SEL_MIXED = 2'b11
  } mode_sel_e;

  typedef enum logic [1:0] {
    ST_PASS  = 2'd0,
    ST_LATCH = 2'd1,
    ST_REG   = 2'd2
  } store_kind_e;

  localparam int unsigned DIR_AB = 0;
  localparam int unsigned DIR_BA = 1;

  // Storage kind for one direction under a given mode code.
  function automatic store_kind_e kind_for(input logic [1:0] sel, input int unsigned dir);
    store_kind_e k;
    case (sel)
      SEL_LATCH: k = ST_LATCH;
      SEL_THRU:  k = ST_PASS;
      SEL_REG:   k = ST_REG;
      default:   k = (dir == DIR_AB) ? ST_REG : ST_LATCH;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import bidir_xcvr_pkg::*;
#(
  parameter int unsigned W = 9
) (
  input  logic [W-1:0] d,
  input  logic         ctl,
  input  store_kind_e  kind,
  output logic [W-1:0] q_n
);

  logic [W-1:0] lat_q;
  logic [W-1:0] reg_q;
  logic [W-1:0] reg_nxt;
  logic [W-1:0] sel_q;

  // Transparent while ctl is low.
  always_latch begin
    if (!ctl) lat_q <= d;
  end

  // Register next state: always the present input.
  always_comb begin
    reg_nxt = d;
  end

  always_ff @(posedge ctl) begin
    reg_q <= reg_nxt;
  end

  // Combinational view select: a mode change acts at once.
  always_comb begin
    case (kind)
      ST_LATCH: sel_q = lat_q;
      ST_REG:   sel_q = reg_q;
      default:  sel_q = d;
    endcase
  end

  assign q_n = ~sel_q;

endmodule

// File: rtl/xcvr_port_ctl.sv
module xcvr_port_ctl #(
  parameter int unsigned W = 9
) (
  input  logic         pwr_good,
  input  logic         b_en0,
  input  logic         b_en1,
  input  logic         a_en,
  input  logic [W-1:0] b_level,
  input  logic [W-1:0] b_di,
  input  logic [W-1:0] b_float,
  output logic [W-1:0] b_pull,
  output logic         a_oe,
  output logic [W-1:0] b_rx
);

  logic b_act;

  always_comb begin
    b_act  = pwr_good & b_en0 & ~b_en1;
    // Open collector: only low levels are driven.
    b_pull = b_act ? ~b_level : '0;
    a_oe   = a_en;
    // Undriven lines are received as low.
    b_rx   = b_di & ~b_float;
  end

endmodule

// File: rtl/bidir_bus_xcvr.sv
module bidir_bus_xcvr
  import bidir_xcvr_pkg::*;
#(
  parameter int unsigned W = 9
) (
  input  logic [1:0]   mode_sel,
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         pwr_good,
  input  logic         a_en,
  input  logic         b_en0,
  input  logic         b_en1,
  input  logic [W-1:0] a_di,
  output logic [W-1:0] a_do,
  output logic         a_oe,
  input  logic [W-1:0] b_di,
  input  logic [W-1:0] b_float,
  output logic [W-1:0] b_pull
);

  localparam int unsigned NDIR = 2;

  logic [W-1:0] b_rx;
  logic [NDIR-1:0][W-1:0] lane_d;
  logic [NDIR-1:0][W-1:0] lane_q_n;
  logic [NDIR-1:0]        lane_ctl;

  always_comb begin
    lane_d[DIR_AB]   = a_di;
    lane_d[DIR_BA]   = b_rx;
    lane_ctl[DIR_AB] = clk_ab;
    lane_ctl[DIR_BA] = clk_ba;
  end

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    store_kind_e kind;
    always_comb kind = kind_for(mode_sel, g);

    xcvr_lane #(.W(W)) u_lane (
      .d    (lane_d[g]),
      .ctl  (lane_ctl[g]),
      .kind (kind),
      .q_n  (lane_q_n[g])
    );
  end

  xcvr_port_ctl #(.W(W)) u_ports (
    .pwr_good (pwr_good),
    .b_en0    (b_en0),
    .b_en1    (b_en1),
    .a_en     (a_en),
    .b_level  (lane_q_n[DIR_AB]),
    .b_di     (b_di),
    .b_float  (b_float),
    .b_pull   (b_pull),
    .a_oe     (a_oe),
    .b_rx     (b_rx)
  );

  assign a_do = lane_q_n[DIR_BA];

endmodule

// File: rtl/bidir_bus_xcvr_chk.sv
module bidir_bus_xcvr_chk
  import bidir_xcvr_pkg::*;
#(
  parameter int unsigned W = 9
) (
  input logic [1:0]   mode_sel,
  input logic         clk_ab,
  input logic         clk_ba,
  input logic         pwr_good,
  input logic         a_en,
  input logic         b_en0,
  input logic         b_en1,
  input logic [W-1:0] a_di,
  input logic [W-1:0] a_do,
  input logic         a_oe,
  input logic [W-1:0] b_di,
  input logic [W-1:0] b_float,
  input logic [W-1:0] b_pull
);

  logic ab_seen;
  logic ba_seen;

  always_ff @(posedge clk_ab or negedge pwr_good) begin
    if (!pwr_good) ab_seen <= 1'b0;
    else           ab_seen <= 1'b1;
  end

  always_ff @(posedge clk_ba or negedge pwr_good) begin
    if (!pwr_good) ba_seen <= 1'b0;
    else           ba_seen <= 1'b1;
  end

  // R10: no pull while power is not good
  a_r10_pwr_gate: assert property (@(posedge clk_ab)
    !pwr_good |-> (b_pull == '0));

  // R6: only enable pair (1,0) lets B drive
  a_r6_b_enable: assert property (@(posedge clk_ab) disable iff (!pwr_good)
    !(b_en0 && !b_en1) |-> (b_pull == '0));

  // R3: A-to-B register shows the value present at the previous clk_ab edge
  a_r3_ab_register: assert property (@(posedge clk_ab) disable iff (!pwr_good)
    (ab_seen && (mode_sel == SEL_REG || mode_sel == SEL_MIXED) && b_en0 && !b_en1)
    |-> (b_pull == $past(a_di)));

  // R3: B-to-A register shows the inverse of the value at the previous clk_ba edge
  a_r3_ba_register: assert property (@(posedge clk_ba) disable iff (!pwr_good)
    (ba_seen && mode_sel == SEL_REG && a_en)
    |-> (a_do == ~$past(b_di & ~b_float)));

  // R2: pass-through inverts B to A
  a_r2_thru_invert: assert property (@(posedge clk_ba) disable iff (!pwr_good)
    (mode_sel == SEL_THRU) |-> (a_do == ~(b_di & ~b_float)));

endmodule

bind bidir_bus_xcvr bidir_bus_xcvr_chk #(.W(W)) u_chk (.*);

// File: tb/tb_bidir_bus_xcvr.sv
`timescale 1ns/1ps
module tb_bidir_bus_xcvr;

  localparam int W = 9;

  logic         clk = 1'b0;
  logic [1:0]   mode_sel;
  logic         clk_ab, clk_ba, pwr_good, a_en, b_en0, b_en1;
  logic [W-1:0] a_di, a_do, b_di, b_float, b_pull;
  logic         a_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bidir_bus_xcvr #(.W(W)) dut (
    .mode_sel (mode_sel), .clk_ab (clk_ab), .clk_ba (clk_ba),
    .pwr_good (pwr_good), .a_en (a_en), .b_en0 (b_en0), .b_en1 (b_en1),
    .a_di (a_di), .a_do (a_do), .a_oe (a_oe),
    .b_di (b_di), .b_float (b_float), .b_pull (b_pull)
  );

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] fl;
  } vec_t;

  localparam vec_t THRU_VEC [6] = '{
    '{a: 9'h000, b: 9'h1FF, fl: 9'h000},
    '{a: 9'h1FF, b: 9'h000, fl: 9'h000},
    '{a: 9'h155, b: 9'h0AA, fl: 9'h000},
    '{a: 9'h0F0, b: 9'h10F, fl: 9'h000},
    '{a: 9'h123, b: 9'h1FF, fl: 9'h0F0},
    '{a: 9'h001, b: 9'h100, fl: 9'h000}
  };

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic settle;
    #1;
  endtask

  task automatic set_ab(input logic v);
    step(); clk_ab = v; settle();
  endtask

  task automatic set_ba(input logic v);
    step(); clk_ba = v; settle();
  endtask

  task automatic set_mode(input logic [1:0] m);
    step(); mode_sel = m; settle();
  endtask

  task automatic set_a(input logic [W-1:0] v);
    step(); a_di = v; settle();
  endtask

  task automatic set_b(input logic [W-1:0] v, input logic [W-1:0] f);
    step(); b_di = v; b_float = f; settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mode_sel = 2'b01; clk_ab = 0; clk_ba = 0; pwr_good = 0;
    a_en = 1; b_en0 = 1; b_en1 = 0;
    a_di = 9'h1FF; b_di = '0; b_float = '0;
    repeat (3) step();
    settle();
    // R10: power-off state, B released
    chk("R10 b_pull power off", b_pull, '0);
    step(); pwr_good = 1; settle();
    chk("R10 b line after power good", ~b_pull, ~a_di);

    // R2 / R7: pass-through vectors
    foreach (THRU_VEC[i]) begin
      step();
      a_di = THRU_VEC[i].a; b_di = THRU_VEC[i].b; b_float = THRU_VEC[i].fl;
      settle();
      chk("R2 thru b line", ~b_pull, ~THRU_VEC[i].a);
      chk("R2 thru a_do", a_do, ~(THRU_VEC[i].b & ~THRU_VEC[i].fl));
      chk("R7 pull only low lanes", b_pull, THRU_VEC[i].a);
    end
    set_b(9'h000, 9'h000);

    // R5: A enable
    step(); a_en = 0; settle();
    chk("R5 a_oe off", {8'h0, a_oe}, 9'h0);
    step(); a_en = 1; settle();
    chk("R5 a_oe on", {8'h0, a_oe}, 9'h1);

    // R6: enable pairs
    set_a(9'h1FF);
    step(); b_en0 = 0; b_en1 = 0; settle();
    chk("R6 en 00", b_pull, '0);
    step(); b_en0 = 1; b_en1 = 1; settle();
    chk("R6 en 11", b_pull, '0);
    step(); b_en0 = 0; b_en1 = 1; settle();
    chk("R6 en 01", b_pull, '0);
    step(); b_en0 = 1; b_en1 = 0; settle();
    chk("R6 en 10", b_pull, 9'h1FF);

    // R3: register mode, separate clocks
    set_a(9'h0A5); set_b(9'h03C, 9'h000);
    set_mode(2'b10);
    set_ab(1);
    chk("R3 ab load", ~b_pull, ~9'h0A5);
    set_a(9'h15A);
    chk("R3 ab hold", ~b_pull, ~9'h0A5);
    set_ab(0);
    chk("R3 ab falling edge", ~b_pull, ~9'h0A5);
    set_ba(1);
    chk("R3 ba load", a_do, ~9'h03C);
    chk("R3 clk_ba leaves ab", ~b_pull, ~9'h0A5);
    set_b(9'h1C3, 9'h000);
    chk("R3 ba hold", a_do, ~9'h03C);

    // R4: latch mode
    set_ba(0);
    set_mode(2'b00);
    set_a(9'h0F0);
    chk("R4 ab transparent", ~b_pull, ~9'h0F0);
    set_a(9'h10F);
    chk("R4 ab follows", ~b_pull, ~9'h10F);
    set_ab(1);
    set_a(9'h0AA);
    chk("R4 ab holds", ~b_pull, ~9'h10F);
    set_b(9'h055, 9'h000);
    chk("R4 ba transparent", a_do, ~9'h055);
    set_ba(1);
    set_b(9'h1AA, 9'h000);
    chk("R4 ba holds", a_do, ~9'h055);

    // R1: mixed code, A-to-B register, B-to-A latch
    set_mode(2'b11);
    chk("R1 mixed ab reg view", ~b_pull, ~9'h10F);
    chk("R1 mixed ba latch view", a_do, ~9'h055);
    set_ba(0);
    chk("R1 mixed ba transparent", a_do, ~9'h1AA);
    set_ab(0);
    chk("R1 mixed ab not transparent", ~b_pull, ~9'h10F);
    set_ab(1);
    chk("R1 mixed ab edge load", ~b_pull, ~9'h0AA);

    // R11: immediate switch between held views
    set_ab(0);
    set_a(9'h1E1);
    set_mode(2'b10);
    chk("R11 reg view", ~b_pull, ~9'h0AA);
    set_mode(2'b00);
    chk("R11 latch view", ~b_pull, ~9'h1E1);
    set_mode(2'b10);
    chk("R11 back to reg", ~b_pull, ~9'h0AA);

    // R8: loading while disabled
    step(); b_en0 = 0; settle();
    set_a(9'h0C3);
    set_ab(1);
    chk("R8 b released while disabled", b_pull, '0);
    step(); b_en0 = 1; settle();
    chk("R8 b shows data loaded while off", ~b_pull, ~9'h0C3);
    step(); a_en = 0; settle();
    set_b(9'h111, 9'h000);
    set_ba(1);
    chk("R8 a_oe off during load", {8'h0, a_oe}, 9'h0);
    step(); a_en = 1; settle();
    chk("R8 a shows data loaded while off", a_do, ~9'h111);

    // R9: floating B lanes read low
    set_mode(2'b01);
    set_b(9'h1FF, 9'h1FF);
    chk("R9 all floating", a_do, 9'h1FF);
    set_b(9'h1FF, 9'h00F);
    chk("R9 some floating", a_do, 9'h00F);

    // R10: power loss gates B, A unaffected
    set_a(9'h1FF);
    step(); pwr_good = 0; settle();
    chk("R10 b released on power loss", b_pull, '0);
    chk("R10 a_oe unaffected", {8'h0, a_oe}, 9'h1);
    step(); pwr_good = 1; settle();
    chk("R10 b back on", b_pull, 9'h1FF);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule